// File: doc/BRIEF.md
# Indexed Vector Gather/Scatter Unit

This unit carries out indexed vector memory accesses for a vector datapath. A gather takes an index vector that an earlier unit-stride load has already placed in a vector register, adds each index to a scalar base address, and reads memory at each resulting address. The values that come back are placed one after another, starting at element 0, into a destination vector register that the unit holds. A scatter takes a data vector and an index vector and writes data element i to the address formed from index i. It writes nothing else, so every other memory word keeps its contents.

A command is a single-cycle `start` pulse. It carries the operation, the base address, the element count and the two vector operands, and the unit copies all of them when the command is accepted. The unit then sends one memory request per accepted handshake on a valid/ready request channel, in ascending element order. Gather read data comes back in order on a response channel. When the last read response or the last write has been accepted, the unit raises `done` for one cycle.

Memory is byte-addressed. Each index is an unsigned count of elements and is scaled by the element size in bytes before it is added to the base.

Top module: `idx_access_unit`

## Requirements
- R1: The address of element i is `base_addr + idx_i * (DW/8)`, where idx_i is bits [i*IW +: IW] of `idx_vec`, read as an unsigned number.
- R2: Requests go out in ascending element order, one per cycle in which `req_valid` and `req_ready` are both high. When two scatter indices are equal, the higher-numbered element is written last.
- R3: In a gather, the k-th accepted response, counting from 0, is written into destination element k, which is bits [k*DW +: DW] of `dst_vec`.
- R4: A scatter writes data element i (`wdata_vec[i*DW +: DW]`) only to the address of element i. Every memory location that no processed index names is left unchanged.
- R5: Only the first `min(vlen, NELEM)` elements are processed. Destination elements at or above that count keep their previous values.
- R6: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr`, `req_wdata` and `req_write` hold their values into the next cycle.
- R7: `done` is high for exactly one cycle. It is high in the cycle after the edge that follows the last accepted response (gather) or the last accepted write (scatter), and `busy` is low in that cycle. A command with `vlen = 0` issues no request and still produces `done`.
- R8: After reset, `busy`, `done` and `req_valid` are low and every destination element is zero.
- R9: A `start` pulse that arrives while `busy` is high is ignored. The running operation finishes with its original operands.
- R10: `op_scatter` = 1 selects scatter, which issues requests with `req_write` = 1. `op_scatter` = 0 selects gather, which issues requests with `req_write` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Command pulse; accepted only while idle |
| op_scatter | input | 1 | 1 = scatter, 0 = gather |
| base_addr | input | AW | Scalar base byte address |
| vlen | input | LW | Number of elements to process |
| idx_vec | input | NELEM*IW | Index vector, element i at bits [i*IW +: IW] |
| wdata_vec | input | NELEM*DW | Scatter data vector |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory accepts request |
| req_write | output | 1 | 1 = write request, 0 = read request |
| req_addr | output | AW | Request byte address |
| req_wdata | output | DW | Write data |
| rsp_valid | input | 1 | Read response valid |
| rsp_data | input | DW | Read response data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| dst_vec | output | NELEM*DW | Destination vector register |

## Verification
A destination element changes at the clock edge that accepts its response, so the bench reads `dst_vec` only after `done`, at a falling edge. The bench records the cycle of the last accepted write or response. `done` must then be seen high at the second rising edge after it, which is the edge following the one at which the unit registers completion, and the bench compares the two cycle numbers. Memory contents and the logged request addresses are checked once the operation has finished. The hold rule for a stalled request is checked at the first rising edge after each stall.

// File: rtl/ixu_pkg.sv
package ixu_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ixu_state_e;
endpackage

// File: rtl/ixu_ctrl.sv
module ixu_ctrl
  import ixu_pkg::*;
#(
  parameter int NELEM = 8,
  parameter int AW    = 16,
  parameter int LW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_scatter,
  input  logic [AW-1:0] base_addr,
  input  logic [LW-1:0] vlen,
  input  logic [LW-1:0] iss_cnt,
  input  logic [LW-1:0] rsp_cnt,
  output logic          launch,
  output logic          busy,
  output logic          done,
  output logic          op_q,
  output logic [AW-1:0] base_q,
  output logic [LW-1:0] len_q
);
  ixu_state_e state;
  logic       complete;

  // Element count limited to the register length.
  function automatic logic [LW-1:0] clamp_len(input logic [LW-1:0] n);
    return (n > LW'(NELEM)) ? LW'(NELEM) : n;
  endfunction

  assign launch   = start && (state == ST_IDLE);
  assign busy     = (state == ST_RUN);
  assign complete = op_q ? (iss_cnt == len_q) : (rsp_cnt == len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      done   <= 1'b0;
      op_q   <= 1'b0;
      base_q <= '0;
      len_q  <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          op_q   <= op_scatter;
          base_q <= base_addr;
          len_q  <= clamp_len(vlen);
          state  <= ST_RUN;
        end
        ST_RUN: if (complete) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ixu_issue.sv
module ixu_issue #(
  parameter int NELEM = 8,
  parameter int DW    = 32,
  parameter int IW    = 8,
  parameter int AW    = 16,
  parameter int LW    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                launch,
  input  logic                busy,
  input  logic                op_q,
  input  logic [AW-1:0]       base_q,
  input  logic [LW-1:0]       len_q,
  input  logic [NELEM*IW-1:0] idx_vec,
  input  logic [NELEM*DW-1:0] wdata_vec,
  input  logic                req_ready,
  output logic                req_valid,
  output logic                req_write,
  output logic [AW-1:0]       req_addr,
  output logic [DW-1:0]       req_wdata,
  output logic                req_fire,
  output logic [LW-1:0]       iss_cnt
);
  localparam int SHIFT = $clog2(DW / 8);
  localparam int SW    = (NELEM > 1) ? $clog2(NELEM) : 1;

  logic [IW-1:0] idx_q [NELEM];
  logic [DW-1:0] dat_q [NELEM];
  logic [SW-1:0] sel;

  // Byte address of one element: base plus unsigned index scaled by element size.
  function automatic logic [AW-1:0] elem_addr(input logic [AW-1:0] b,
                                              input logic [IW-1:0] ix);
    return b + (AW'(ix) << SHIFT);
  endfunction

  for (genvar e = 0; e < NELEM; e++) begin : g_opnd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        idx_q[e] <= '0;
        dat_q[e] <= '0;
      end else if (launch) begin
        idx_q[e] <= idx_vec[e*IW +: IW];
        dat_q[e] <= wdata_vec[e*DW +: DW];
      end
    end
  end

  assign sel       = iss_cnt[SW-1:0];
  assign req_valid = busy && (iss_cnt < len_q);
  assign req_write = op_q;
  assign req_addr  = elem_addr(base_q, idx_q[sel]);
  assign req_wdata = dat_q[sel];
  assign req_fire  = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        iss_cnt <= '0;
    else if (launch)   iss_cnt <= '0;
    else if (req_fire) iss_cnt <= iss_cnt + 1'b1;
  end
endmodule

// File: rtl/ixu_collect.sv
module ixu_collect #(
  parameter int NELEM = 8,
  parameter int DW    = 32,
  parameter int LW    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                launch,
  input  logic                busy,
  input  logic                op_q,
  input  logic [LW-1:0]       iss_cnt,
  input  logic                rsp_valid,
  input  logic [DW-1:0]       rsp_data,
  output logic                rsp_accept,
  output logic [LW-1:0]       rsp_cnt,
  output logic [NELEM*DW-1:0] dst_vec
);
  // A response counts only for a gather with a read still outstanding.
  assign rsp_accept = busy && !op_q && rsp_valid && (rsp_cnt < iss_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rsp_cnt <= '0;
    else if (launch)     rsp_cnt <= '0;
    else if (rsp_accept) rsp_cnt <= rsp_cnt + 1'b1;
  end

  for (genvar e = 0; e < NELEM; e++) begin : g_dst
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        dst_vec[e*DW +: DW] <= '0;
      else if (rsp_accept && (rsp_cnt == LW'(e)))
        dst_vec[e*DW +: DW] <= rsp_data;
    end
  end
endmodule

// File: rtl/idx_access_unit.sv
module idx_access_unit #(
  parameter int NELEM = 8,
  parameter int DW    = 32,
  parameter int IW    = 8,
  parameter int AW    = 16,
  localparam int LW   = $clog2(NELEM + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                op_scatter,
  input  logic [AW-1:0]       base_addr,
  input  logic [LW-1:0]       vlen,
  input  logic [NELEM*IW-1:0] idx_vec,
  input  logic [NELEM*DW-1:0] wdata_vec,
  output logic                req_valid,
  input  logic                req_ready,
  output logic                req_write,
  output logic [AW-1:0]       req_addr,
  output logic [DW-1:0]       req_wdata,
  input  logic                rsp_valid,
  input  logic [DW-1:0]       rsp_data,
  output logic                busy,
  output logic                done,
  output logic [NELEM*DW-1:0] dst_vec
);
  // Internal events brought out as named wires for the checker.
  logic          launch;
  logic          op_q;
  logic [AW-1:0] base_q;
  logic [LW-1:0] len_q;
  logic [LW-1:0] iss_cnt;
  logic [LW-1:0] rsp_cnt;
  logic          req_fire;
  logic          rsp_accept;

  ixu_ctrl #(.NELEM(NELEM), .AW(AW), .LW(LW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .op_scatter(op_scatter),
    .base_addr(base_addr), .vlen(vlen), .iss_cnt(iss_cnt), .rsp_cnt(rsp_cnt),
    .launch(launch), .busy(busy), .done(done), .op_q(op_q),
    .base_q(base_q), .len_q(len_q)
  );

  ixu_issue #(.NELEM(NELEM), .DW(DW), .IW(IW), .AW(AW), .LW(LW)) u_issue (
    .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy), .op_q(op_q),
    .base_q(base_q), .len_q(len_q), .idx_vec(idx_vec), .wdata_vec(wdata_vec),
    .req_ready(req_ready), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_fire(req_fire),
    .iss_cnt(iss_cnt)
  );

  ixu_collect #(.NELEM(NELEM), .DW(DW), .LW(LW)) u_collect (
    .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy), .op_q(op_q),
    .iss_cnt(iss_cnt), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_accept(rsp_accept), .rsp_cnt(rsp_cnt), .dst_vec(dst_vec)
  );
endmodule

// File: rtl/ixu_checker.sv
module ixu_checker #(
  parameter int NELEM = 8,
  parameter int DW    = 32,
  parameter int AW    = 16,
  parameter int LW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [DW-1:0] req_wdata,
  input logic          op_q,
  input logic [LW-1:0] len_q,
  input logic [LW-1:0] iss_cnt,
  input logic [LW-1:0] rsp_cnt
);
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr)
                                && $stable(req_wdata) && $stable(req_write));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && iss_cnt == len_q);

  assert_gather_drained_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done && !op_q |-> rsp_cnt == len_q);

  assert_rsp_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_cnt <= iss_cnt);

  assert_len_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= LW'(NELEM));

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(len_q) && $stable(op_q));
endmodule

bind idx_access_unit ixu_checker #(.NELEM(NELEM), .DW(DW), .AW(AW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .op_q(op_q), .len_q(len_q),
  .iss_cnt(iss_cnt), .rsp_cnt(rsp_cnt)
);

// File: tb/idx_access_unit_bench.sv
module idx_access_unit_bench;
  localparam int NELEM = 8;
  localparam int DW    = 32;
  localparam int IW    = 8;
  localparam int AW    = 16;
  localparam int LW    = $clog2(NELEM + 1);

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                start = 1'b0;
  logic                op_scatter = 1'b0;
  logic [AW-1:0]       base_addr = '0;
  logic [LW-1:0]       vlen = '0;
  logic [NELEM*IW-1:0] idx_vec = '0;
  logic [NELEM*DW-1:0] wdata_vec = '0;
  logic                req_valid, req_write;
  logic                req_ready = 1'b1;
  logic [AW-1:0]       req_addr;
  logic [DW-1:0]       req_wdata;
  logic                rsp_valid = 1'b0;
  logic [DW-1:0]       rsp_data = '0;
  logic                busy, done;
  logic [NELEM*DW-1:0] dst_vec;

  idx_access_unit #(.NELEM(NELEM), .DW(DW), .IW(IW), .AW(AW)) u_idx_access_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op_scatter(op_scatter),
    .base_addr(base_addr), .vlen(vlen), .idx_vec(idx_vec), .wdata_vec(wdata_vec),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .busy(busy), .done(done), .dst_vec(dst_vec)
  );

  always #10 clk = ~clk;  // 50 MHz

  int n_checks = 0;
  int n_fail   = 0;

  // Memory model and monitor state
  logic [DW-1:0] mem [64];
  logic [AW-1:0] req_log [256];
  logic          wr_log  [256];
  int            req_n = 0;
  int            cyc = 0;
  int            last_act = 0;
  int            done_cyc = 0;
  bit            stall_mode = 1'b0;
  logic [7:0]    lfsr = 8'hA5;
  logic          prev_stall = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  logic [DW-1:0] prev_wdata = '0;
  logic [DW-1:0] exp_dst [NELEM];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    req_ready <= stall_mode ? lfsr[0] : 1'b1;
    if (prev_stall) begin
      n_checks++;
      if (!(req_valid && req_addr == prev_addr && req_wdata == prev_wdata)) begin
        n_fail++;
        $display("FAIL R6 stall hold: actual=%0h expected=%0h", req_addr, prev_addr);
      end
    end
    prev_stall <= req_valid && !req_ready;
    prev_addr  <= req_addr;
    prev_wdata <= req_wdata;
    if (done) done_cyc <= cyc;
    if (rsp_valid) last_act <= cyc;
    if (req_valid && req_ready) begin
      req_log[req_n[7:0]] <= req_addr;
      wr_log[req_n[7:0]]  <= req_write;
      req_n <= req_n + 1;
      if (req_write) begin
        mem[req_addr[7:2]] <= req_wdata;
        last_act <= cyc;
      end
      rsp_valid <= !req_write;
      rsp_data  <= mem[req_addr[7:2]];
    end else begin
      rsp_valid <= 1'b0;
    end
  end

  task automatic set_vecs(input logic [IW-1:0] ix [NELEM], input logic [DW-1:0] dv [NELEM]);
    for (int e = 0; e < NELEM; e++) begin
      idx_vec[e*IW +: IW]   = ix[e];
      wdata_vec[e*DW +: DW] = dv[e];
    end
  endtask

  task automatic run_op(input bit scat, input logic [AW-1:0] b, input logic [LW-1:0] n);
    @(negedge clk);
    op_scatter = scat;
    base_addr  = b;
    vlen       = n;
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 2000; k++) begin
      if (done) break;
      @(negedge clk);
    end
    chk(done && !busy, "R7 done with busy low", {30'd0, busy, done}, 32'd1);
    @(negedge clk);
    chk(!done, "R7 done lasts one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic check_dst(input string tag);
    for (int e = 0; e < NELEM; e++)
      chk(dst_vec[e*DW +: DW] == exp_dst[e], tag, dst_vec[e*DW +: DW], exp_dst[e]);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !req_valid, "R8 reset outputs", {29'd0, busy, done, req_valid}, 32'd0);
    for (int e = 0; e < NELEM; e++) exp_dst[e] = '0;
    check_dst("R8 reset destination");
  endtask

  task automatic t_gather_basic;
    logic [IW-1:0] ix [NELEM];
    logic [DW-1:0] dv [NELEM];
    int s;
    ix = '{8'd3, 8'd0, 8'd5, 8'd1, 8'd2, 8'd7, 8'd4, 8'd6};
    for (int e = 0; e < NELEM; e++) dv[e] = '0;
    set_vecs(ix, dv);
    s = req_n;
    run_op(1'b0, 16'h0040, 4'd8);
    for (int e = 0; e < NELEM; e++) begin
      exp_dst[e] = 32'hA000 + 32'(16 + ix[e]);
      chk(req_log[s+e] == 16'h0040 + 16'(ix[e]) * 16'd4, "R1 R2 gather address order",
          32'(req_log[s+e]), 32'(16'h0040 + 16'(ix[e]) * 16'd4));
      chk(wr_log[s+e] == 1'b0, "R10 gather reads", 32'(wr_log[s+e]), 32'd0);
    end
    check_dst("R3 gather packing");
    chk(done_cyc == last_act + 2, "R7 gather done timing", done_cyc, last_act + 2);
  endtask

  task automatic t_gather_stall;
    logic [IW-1:0] ix [NELEM];
    logic [DW-1:0] dv [NELEM];
    ix = '{8'd9, 8'd8, 8'd15, 8'd10, 8'd12, 8'd0, 8'd0, 8'd0};
    for (int e = 0; e < NELEM; e++) dv[e] = '0;
    set_vecs(ix, dv);
    stall_mode = 1'b1;
    run_op(1'b0, 16'h0040, 4'd5);
    stall_mode = 1'b0;
    for (int e = 0; e < 5; e++) exp_dst[e] = 32'hA000 + 32'(16 + ix[e]);
    check_dst("R5 R6 partial gather under stalls");
  endtask

  task automatic t_scatter;
    logic [IW-1:0] ix [NELEM];
    logic [DW-1:0] dv [NELEM];
    int s;
    ix = '{8'd0, 8'd2, 8'd6, 8'd7, 8'd1, 8'd3, 8'd4, 8'd5};
    for (int e = 0; e < NELEM; e++) dv[e] = 32'h5C00 + 32'(e);
    set_vecs(ix, dv);
    s = req_n;
    run_op(1'b1, 16'h0080, 4'd4);
    chk(req_n - s == 4, "R4 scatter write count", req_n - s, 32'd4);
    for (int e = 0; e < 4; e++)
      chk(wr_log[s+e] == 1'b1, "R10 scatter writes", 32'(wr_log[s+e]), 32'd1);
    chk(mem[32] == 32'h5C00, "R4 scatter base+0", mem[32], 32'h5C00);
    chk(mem[34] == 32'h5C01, "R4 scatter base+2", mem[34], 32'h5C01);
    chk(mem[38] == 32'h5C02, "R4 scatter base+6", mem[38], 32'h5C02);
    chk(mem[39] == 32'h5C03, "R4 scatter base+7", mem[39], 32'h5C03);
    for (int w = 33; w < 38; w++)
      if (w != 34)
        chk(mem[w] == 32'hDEAD0000 + 32'(w), "R4 untouched location", mem[w],
            32'hDEAD0000 + 32'(w));
    chk(done_cyc == last_act + 2, "R7 scatter done timing", done_cyc, last_act + 2);
    check_dst("R4 scatter leaves destination");
  endtask

  task automatic t_scatter_dup;
    logic [IW-1:0] ix [NELEM];
    logic [DW-1:0] dv [NELEM];
    ix = '{8'd5, 8'd5, 8'd5, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0};
    for (int e = 0; e < NELEM; e++) dv[e] = 32'h7700 + 32'(e);
    set_vecs(ix, dv);
    stall_mode = 1'b1;
    run_op(1'b1, 16'h00A0, 4'd3);
    stall_mode = 1'b0;
    chk(mem[45] == 32'h7702, "R2 duplicate index last write wins", mem[45], 32'h7702);
    chk(mem[40] == 32'hDEAD0000 + 32'd40, "R5 element past vlen not written", mem[40],
        32'hDEAD0000 + 32'd40);
  endtask

  task automatic t_vlen_zero;
    int s;
    s = req_n;
    run_op(1'b0, 16'h0000, 4'd0);
    chk(req_n == s, "R7 zero length issues nothing", req_n - s, 32'd0);
    check_dst("R5 zero length keeps destination");
  endtask

  task automatic t_clamp;
    logic [IW-1:0] ix [NELEM];
    logic [DW-1:0] dv [NELEM];
    int s;
    ix = '{8'd7, 8'd6, 8'd5, 8'd4, 8'd3, 8'd2, 8'd1, 8'd0};
    for (int e = 0; e < NELEM; e++) dv[e] = '0;
    set_vecs(ix, dv);
    s = req_n;
    run_op(1'b0, 16'h0000, 4'd15);
    chk(req_n - s == NELEM, "R5 length clamped to register size", req_n - s, NELEM);
    for (int e = 0; e < NELEM; e++) exp_dst[e] = 32'hA000 + 32'(ix[e]);
    check_dst("R5 clamped gather");
  endtask

  task automatic t_busy_start;
    logic [IW-1:0] ix [NELEM];
    logic [DW-1:0] dv [NELEM];
    int s;
    ix = '{8'd1, 8'd3, 8'd5, 8'd7, 8'd0, 8'd2, 8'd4, 8'd6};
    for (int e = 0; e < NELEM; e++) dv[e] = '0;
    set_vecs(ix, dv);
    s = req_n;
    stall_mode = 1'b1;
    @(negedge clk);
    op_scatter = 1'b0; base_addr = 16'h0040; vlen = 4'd8; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    op_scatter = 1'b1; base_addr = 16'h0000; vlen = 4'd2; start = 1'b1;
    for (int e = 0; e < NELEM; e++) idx_vec[e*IW +: IW] = 8'd0;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 2000; k++) begin
      if (done) break;
      @(negedge clk);
    end
    stall_mode = 1'b0;
    @(negedge clk);
    chk(req_n - s == NELEM, "R9 start while busy ignored", req_n - s, NELEM);
    for (int e = 0; e < NELEM; e++) exp_dst[e] = 32'hA000 + 32'(16 + ix[e]);
    check_dst("R9 original operands used");
  endtask

  initial begin
    for (int w = 0; w < 64; w++) mem[w] = (w < 32) ? 32'hA000 + 32'(w) : 32'hDEAD0000 + 32'(w);
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_gather_basic;
    t_gather_stall;
    t_scatter;
    t_scatter_dup;
    t_vlen_zero;
    t_clamp;
    t_busy_start;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 50000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule